// File: doc/BRIEF.md
# Memory Access Exception Checker

This block sits next to a processor's fetch and load/store path and decides whether a memory access must raise a hardware exception. It checks two things. First, any access flagged as a stack access is tested against a low and a high stack bound. Second, the bus response of every access is watched for an error. When either check fails and the exception is allowed, the block emits a one-cycle exception request. In the same cycle it loads a cause register and a fault-address register. Both registers hold their values until the next exception. Trap vectoring and the memory system are outside this block.

Only one access is tracked at a time. The block runs a small state machine:
- `ST_IDLE` accepts a new access (`acc_valid`).
- A clean acceptance moves to `ST_WAIT`, which waits for the bus response.
- A stack violation raises its exception immediately and moves to `ST_DRAIN`. That state absorbs the pending bus response without acting on it, so a stack fault always wins over a bus error on the same access.
- Any response (`rsp_valid`) returns `ST_WAIT` or `ST_DRAIN` to `ST_IDLE`.

Bus-error exceptions need the status-register exception-enable bit. They also need the configuration bit of the bus involved: the instruction bus for fetches, the data bus for loads and stores.

Top module: `mem_exc_checker`

## Requirements
- R1: After reset `exc_req` is 0, `exc_cause` is 0 and `exc_addr` is 0.
- R2: An access accepted in `ST_IDLE` with `acc_stack`=1 and `acc_addr` < `stk_lo` behaves as follows. One cycle after the accepting edge, `exc_req` is 1, `exc_cause` is 7 (stack code) and `exc_addr` equals that `acc_addr`. No exception-enable or configuration bit gates this.
- R3: The same holds for a stack access with `acc_addr` > `stk_hi`.
- R4: Both bounds are inclusive. A stack access at exactly `stk_lo` or exactly `stk_hi` raises nothing. An access with `acc_stack`=0 is never bound-checked.
- R5: `acc_kind` encodes 0=fetch, 1=load, 2=store, 3=treated as data. Consider a fetch whose response has `rsp_err`=1 while `exc_en`=1 and `ibus_exc_cfg`=1. One cycle after the response edge, `exc_req` is 1, `exc_cause` is 3 (instruction-bus code) and `exc_addr` is the access address.
- R6: Consider a load or store whose response has `rsp_err`=1 while `exc_en`=1 and `dbus_exc_cfg`=1. It raises `exc_req` with `exc_cause` 4 (data-bus code) and the access address.
- R7: Each bus is gated only by its own configuration bit. A fetch error with `ibus_exc_cfg`=0 raises nothing even when `dbus_exc_cfg`=1. A data error with `dbus_exc_cfg`=0 raises nothing even when `ibus_exc_cfg`=1.
- R8: With `exc_en`=0 a bus error is dropped: no request, and `exc_cause`/`exc_addr` keep their previous values.
- R9: When a stack violation and a bus error hit the same access, exactly one exception is raised, carrying the stack code. The later error response is discarded.
- R10: `exc_cause` and `exc_addr` change only in a cycle where `exc_req` is 1.
- R11: `exc_req` is a one-cycle pulse. After a stack exception it is 0 in the next cycle.
- R12: An `acc_valid` presented while a response is still awaited is ignored, even if it violates the stack bounds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | New access presented this cycle |
| acc_addr | input | ADDR_W | Access address |
| acc_kind | input | 2 | 0 fetch, 1 load, 2 store, 3 data |
| acc_stack | input | 1 | Access is a stack access |
| stk_lo | input | ADDR_W | Lowest legal stack address (inclusive) |
| stk_hi | input | ADDR_W | Highest legal stack address (inclusive) |
| rsp_valid | input | 1 | Bus response for the pending access |
| rsp_err | input | 1 | Bus response reports an error |
| exc_en | input | 1 | Status-register exception enable |
| ibus_exc_cfg | input | 1 | Instruction-bus error exceptions configured |
| dbus_exc_cfg | input | 1 | Data-bus error exceptions configured |
| exc_req | output | 1 | One-cycle exception request |
| exc_cause | output | 5 | Exception cause register |
| exc_addr | output | ADDR_W | Exception (fault) address register |

## Verification
Stack accesses are driven just below the low bound, just above the high bound and exactly on each bound. These patterns separate a strict comparison from an inclusive one, and a non-stack access outside the window shows that the qualifier gates the check. Bus errors are sent on every access kind under each combination of the two configuration bits and the enable bit. This reveals a swapped cause code, a configuration bit routed to the wrong bus, or a missing enable gate. Further sequences test priority and holding behaviour:
- a stack fault followed by an erroring response;
- a second access issued while one is pending;
- clean accesses after a fault.

These show whether the priority, the single outstanding access and the register hold are kept.

// File: rtl/mex_pkg.sv
package mex_pkg;

    typedef enum logic [1:0] {
        KIND_FETCH = 2'b00,
        KIND_LOAD  = 2'b01,
        KIND_STORE = 2'b10,
        KIND_DATA  = 2'b11
    } acc_kind_e;

    localparam int CAUSE_W = 5;
    typedef logic [CAUSE_W-1:0] cause_t;

    localparam cause_t CAUSE_NONE  = 5'd0;
    localparam cause_t CAUSE_IBUS  = 5'd3;
    localparam cause_t CAUSE_DBUS  = 5'd4;
    localparam cause_t CAUSE_STACK = 5'd7;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_WAIT  = 2'b01,
        ST_DRAIN = 2'b10
    } mex_state_e;

endpackage

// File: rtl/mex_stack_cmp.sv
module mex_stack_cmp #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              is_stack,
    input  logic [ADDR_W-1:0] bound_lo,
    input  logic [ADDR_W-1:0] bound_hi,
    output logic              violation
);
    logic below_lo;
    logic above_hi;

    // Both bounds are legal addresses themselves.
    always_comb begin
        below_lo  = (addr < bound_lo);
        above_hi  = (addr > bound_hi);
        violation = is_stack && (below_lo || above_hi);
    end
endmodule

// File: rtl/mex_bus_route.sv
module mex_bus_route
    import mex_pkg::*;
(
    input  logic [1:0] kind,
    input  logic       err,
    input  logic       enable,
    input  logic       ibus_cfg,
    input  logic       dbus_cfg,
    output logic       take,
    output cause_t     cause
);
    logic is_fetch;
    logic gate;

    always_comb begin
        is_fetch = (kind == KIND_FETCH);
        gate     = is_fetch ? ibus_cfg : dbus_cfg;
        take     = err && enable && gate;
        cause    = is_fetch ? CAUSE_IBUS : CAUSE_DBUS;
    end
endmodule

// File: rtl/mex_capture.sv
module mex_capture
    import mex_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  cause_t            cause_in,
    input  logic [ADDR_W-1:0] addr_in,
    output logic              req_q,
    output cause_t            cause_q,
    output logic [ADDR_W-1:0] addr_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q   <= 1'b0;
            cause_q <= CAUSE_NONE;
            addr_q  <= '0;
        end else begin
            req_q <= load;
            if (load) begin
                cause_q <= cause_in;
                addr_q  <= addr_in;
            end
        end
    end
endmodule

// File: rtl/mem_exc_checker.sv
module mem_exc_checker
    import mex_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_kind,
    input  logic              acc_stack,
    input  logic [ADDR_W-1:0] stk_lo,
    input  logic [ADDR_W-1:0] stk_hi,
    input  logic              rsp_valid,
    input  logic              rsp_err,
    input  logic              exc_en,
    input  logic              ibus_exc_cfg,
    input  logic              dbus_exc_cfg,
    output logic              exc_req,
    output logic [4:0]        exc_cause,
    output logic [ADDR_W-1:0] exc_addr
);
    mex_state_e        state_q, state_d;
    logic [ADDR_W-1:0] pend_addr_q;
    logic [1:0]        pend_kind_q;
    logic              accept;
    logic              stk_viol;
    logic              bus_take;
    cause_t            bus_cause;
    logic              cap_load;
    cause_t            cap_cause;
    logic [ADDR_W-1:0] cap_addr;
    logic              in_idle;
    logic              in_wait;
    cause_t            cause_reg;

    mex_stack_cmp #(.ADDR_W(ADDR_W)) stk_cmp_i (
        .addr      (acc_addr),
        .is_stack  (acc_stack),
        .bound_lo  (stk_lo),
        .bound_hi  (stk_hi),
        .violation (stk_viol)
    );

    mex_bus_route bus_route_i (
        .kind     (pend_kind_q),
        .err      (rsp_err),
        .enable   (exc_en),
        .ibus_cfg (ibus_exc_cfg),
        .dbus_cfg (dbus_exc_cfg),
        .take     (bus_take),
        .cause    (bus_cause)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            pend_addr_q <= '0;
            pend_kind_q <= 2'b00;
        end else begin
            state_q <= state_d;
            if (accept) begin
                pend_addr_q <= acc_addr;
                pend_kind_q <= acc_kind;
            end
        end
    end

    // Next state and capture control
    always_comb begin
        state_d   = state_q;
        accept    = 1'b0;
        cap_load  = 1'b0;
        cap_cause = CAUSE_NONE;
        cap_addr  = acc_addr;
        unique case (state_q)
            ST_IDLE: begin
                if (acc_valid) begin
                    accept = 1'b1;
                    if (stk_viol) begin
                        cap_load  = 1'b1;
                        cap_cause = CAUSE_STACK;
                        cap_addr  = acc_addr;
                        state_d   = ST_DRAIN;
                    end else begin
                        state_d = ST_WAIT;
                    end
                end
            end
            ST_WAIT: begin
                if (rsp_valid) begin
                    state_d = ST_IDLE;
                    if (bus_take) begin
                        cap_load  = 1'b1;
                        cap_cause = bus_cause;
                        cap_addr  = pend_addr_q;
                    end
                end
            end
            ST_DRAIN: begin
                if (rsp_valid) begin
                    state_d = ST_IDLE;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    mex_capture #(.ADDR_W(ADDR_W)) capture_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cap_load),
        .cause_in (cap_cause),
        .addr_in  (cap_addr),
        .req_q    (exc_req),
        .cause_q  (cause_reg),
        .addr_q   (exc_addr)
    );

    assign exc_cause = cause_reg;
    assign in_idle   = (state_q == ST_IDLE);
    assign in_wait   = (state_q == ST_WAIT);

endmodule

// File: rtl/mem_exc_props.sv
module mem_exc_props #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              acc_stack,
    input logic [ADDR_W-1:0] stk_lo,
    input logic [ADDR_W-1:0] stk_hi,
    input logic              rsp_valid,
    input logic              exc_en,
    input logic              in_idle,
    input logic              in_wait,
    input logic              exc_req,
    input logic [4:0]        exc_cause,
    input logic [ADDR_W-1:0] exc_addr
);
    // R2 R3
    stack_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_idle && acc_valid && acc_stack && (acc_addr < stk_lo || acc_addr > stk_hi))
        |=> (exc_req && exc_cause == 5'd7 && exc_addr == $past(acc_addr)));

    // R4
    inside_bounds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_idle && acc_valid && acc_addr >= stk_lo && acc_addr <= stk_hi)
        |=> !exc_req);

    // R8
    enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_wait && rsp_valid && !exc_en) |=> !exc_req);

    // R10
    hold_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_req |-> ($stable(exc_cause) && $stable(exc_addr)));

    // R11
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req && exc_cause == 5'd7) |=> !exc_req);

    // R12
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_wait && !rsp_valid) |=> !exc_req);

    // R5 R6
    cause_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |-> (exc_cause == 5'd3 || exc_cause == 5'd4 || exc_cause == 5'd7));

endmodule

bind mem_exc_checker mem_exc_props #(.ADDR_W(ADDR_W)) props_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_addr  (acc_addr),
    .acc_stack (acc_stack),
    .stk_lo    (stk_lo),
    .stk_hi    (stk_hi),
    .rsp_valid (rsp_valid),
    .exc_en    (exc_en),
    .in_idle   (in_idle),
    .in_wait   (in_wait),
    .exc_req   (exc_req),
    .exc_cause (exc_cause),
    .exc_addr  (exc_addr)
);

// File: tb/mem_exc_checker_tb_top.sv
`timescale 1ns/1ps
module mem_exc_checker_tb_top;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acc_valid = 1'b0;
    logic [AW-1:0] acc_addr = '0;
    logic [1:0]    acc_kind = 2'b00;
    logic          acc_stack = 1'b0;
    logic [AW-1:0] stk_lo = 32'h0000_1000;
    logic [AW-1:0] stk_hi = 32'h0000_1FFC;
    logic          rsp_valid = 1'b0;
    logic          rsp_err = 1'b0;
    logic          exc_en = 1'b1;
    logic          ibus_exc_cfg = 1'b1;
    logic          dbus_exc_cfg = 1'b1;
    logic          exc_req;
    logic [4:0]    exc_cause;
    logic [AW-1:0] exc_addr;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    mem_exc_checker #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_kind(acc_kind), .acc_stack(acc_stack), .stk_lo(stk_lo), .stk_hi(stk_hi),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .exc_en(exc_en),
        .ibus_exc_cfg(ibus_exc_cfg), .dbus_exc_cfg(dbus_exc_cfg),
        .exc_req(exc_req), .exc_cause(exc_cause), .exc_addr(exc_addr)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // One access: hit1 samples exc_req after the accept edge, hit2 after the response edge.
    task automatic xfer(input logic [31:0] a, input logic [1:0] k, input logic s,
                        input logic e, output logic hit1, output logic hit2);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a; acc_kind = k; acc_stack = s;
        @(negedge clk);
        acc_valid = 1'b0; hit1 = exc_req;
        @(negedge clk);
        rsp_valid = 1'b1; rsp_err = e;
        @(negedge clk);
        rsp_valid = 1'b0; rsp_err = 1'b0; hit2 = exc_req;
    endtask

    task automatic t_reset();
        check("R1 req", exc_req, 0);
        check("R1 cause", exc_cause, 0);
        check("R1 addr", exc_addr, 0);
    endtask

    task automatic t_stack_bounds();
        logic h1, h2;
        xfer(32'h0000_0FFC, 2'd1, 1'b1, 1'b0, h1, h2);
        check("R2 req", h1, 1); check("R2 cause", exc_cause, 7);
        check("R2 addr", exc_addr, 32'h0000_0FFC);
        exc_en = 1'b0;
        xfer(32'h0000_2000, 2'd2, 1'b1, 1'b0, h1, h2);
        exc_en = 1'b1;
        check("R3 req", h1, 1); check("R3 cause", exc_cause, 7);
        check("R3 addr", exc_addr, 32'h0000_2000);
        xfer(32'h0000_1000, 2'd1, 1'b1, 1'b0, h1, h2);
        check("R4 lo edge", h1 | h2, 0);
        xfer(32'h0000_1FFC, 2'd2, 1'b1, 1'b0, h1, h2);
        check("R4 hi edge", h1 | h2, 0);
        xfer(32'h0000_0010, 2'd1, 1'b0, 1'b0, h1, h2);
        check("R4 non-stack", h1 | h2, 0);
        check("R10 hold addr", exc_addr, 32'h0000_2000);
    endtask

    task automatic t_bus_errors();
        logic h1, h2;
        xfer(32'h0000_4000, 2'd0, 1'b0, 1'b1, h1, h2);
        check("R5 req", h2, 1); check("R5 cause", exc_cause, 3);
        check("R5 addr", exc_addr, 32'h0000_4000);
        for (int k = 1; k < 4; k++) begin
            xfer(32'h0000_5000 + k, 2'(k), 1'b0, 1'b1, h1, h2);
            check("R6 req", h2, 1); check("R6 cause", exc_cause, 4);
            check("R6 addr", exc_addr, 32'h0000_5000 + k);
        end
        ibus_exc_cfg = 1'b0;
        xfer(32'h0000_6000, 2'd0, 1'b0, 1'b1, h1, h2);
        check("R7 ibus off", h2, 0);
        ibus_exc_cfg = 1'b1; dbus_exc_cfg = 1'b0;
        xfer(32'h0000_6004, 2'd1, 1'b0, 1'b1, h1, h2);
        check("R7 dbus off", h2, 0);
        check("R7 addr kept", exc_addr, 32'h0000_5003);
        dbus_exc_cfg = 1'b1; exc_en = 1'b0;
        xfer(32'h0000_7000, 2'd0, 1'b0, 1'b1, h1, h2);
        check("R8 req", h2, 0); check("R8 cause", exc_cause, 4);
        check("R8 addr", exc_addr, 32'h0000_5003);
        exc_en = 1'b1;
    endtask

    task automatic t_priority();
        logic h1, h2;
        xfer(32'h0000_0100, 2'd1, 1'b1, 1'b1, h1, h2);
        check("R9 stack req", h1, 1); check("R9 no bus req", h2, 0);
        check("R9 cause", exc_cause, 7); check("R9 addr", exc_addr, 32'h0000_0100);
    endtask

    task automatic t_pulse();
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = 32'h0000_3000; acc_kind = 2'd2; acc_stack = 1'b1;
        @(negedge clk);
        acc_valid = 1'b0;
        check("R11 first", exc_req, 1);
        @(negedge clk);
        check("R11 second", exc_req, 0);
        rsp_valid = 1'b1;
        @(negedge clk);
        rsp_valid = 1'b0;
    endtask

    task automatic t_busy();
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = 32'h0000_1800; acc_kind = 2'd1; acc_stack = 1'b1;
        @(negedge clk);
        acc_addr = 32'h0000_0004;
        @(negedge clk);
        acc_valid = 1'b0;
        check("R12 req", exc_req, 0);
        rsp_valid = 1'b1; rsp_err = 1'b0;
        @(negedge clk);
        rsp_valid = 1'b0;
        @(negedge clk);
        check("R12 req after", exc_req, 0);
        check("R12 addr kept", exc_addr, 32'h0000_3000);
    endtask

    initial begin
        #(200000 * 5);
        bad++;
        $display("FAIL R1 watchdog act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_stack_bounds();
        t_bus_errors();
        t_priority();
        t_pulse();
        t_busy();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule